// File: doc/BRIEF.md
# Debug Emulator Mode Controller

This block sits beside a processor core and decides when the core enters and leaves its debug emulator mode. A breakpoint trigger raises a debug-interrupt request. The request is held until the core's once-per-instruction interrupt sample strobe, and there it outranks every ordinary interrupt level, level 7 included. When the request is accepted, the block presents the debug exception vector number. It drives a distinctive processor status code for a fixed number of cycles and switches the core into emulator mode.

Emulator mode can also be entered from a reset exception or a trace exception, each one gated by its own control bit. While the core is in emulator mode, ordinary interrupts and new breakpoint triggers have no effect. A map control bit redirects every memory access into a dedicated debug address space and turns off caching and on-chip SRAM. A pulse from the return-from-exception instruction ends the mode. Breakpoint triggers are then blocked until the next instruction has retired.

Top module: `dbg_emu_ctrl`

## Requirements
- R1: After synchronous active-low reset, `emu_mode`, `dbg_pend` and `dbg_take` are 0 and `pst` is 0x0. Reset-exception and trigger pulses seen while `rst_n` is low have no effect.
- R2: A `brk_trig` pulse outside emulator mode, with no post-exit block active, sets `dbg_pend` from the next cycle. `dbg_pend` stays set until an `isample` strobe, when `dbg_take` pulses; `dbg_pend` is 0 in the cycle after the take.
- R3: A `brk_trig` that coincides with `isample` is taken in that same cycle (`dbg_take`=1), before the targeted instruction runs.
- R4: When `dbg_take` is 1, `irq_take` is 0 even with `irq_lvl`=7. With nothing pending, no emulator mode and `irq_lvl`≠0, `isample` gives `irq_take`=1.
- R5: `vec_num` is 12 in the cycle `dbg_take` is 1 and 0 otherwise.
- R6: After a debug take, `pst` reads 0xD for exactly 3 consecutive cycles, starting in the cycle after the take, then 0x0.
- R7: `emu_mode` is 1 in the cycle after a debug take.
- R8: A `rst_exc` pulse sets `emu_mode` in the next cycle only if `ctl_emu` is 1.
- R9: A `trc_exc` pulse sets `emu_mode` in the next cycle only if `ctl_trc` is 1.
- R10: In emulator mode `irq_take` and `dbg_take` stay 0 for any `irq_lvl`. A `brk_trig` seen there is discarded, so `dbg_pend` is 0 after exit.
- R11: `rte_done` in emulator mode clears `emu_mode` in the next cycle. Triggers are then discarded, even when they coincide with `isample`, until an `instr_ret` pulse has been seen.
- R12: In emulator mode with `ctl_map`=1, `tt_out`=2, `tm_out`=5 for data (`acc_ifetch`=0) or 6 for fetches (`acc_ifetch`=1), and `cache_off`=1. In all other cases `tt_out`/`tm_out` equal `tt_in`/`tm_in` and `cache_off`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| brk_trig | input | 1 | Breakpoint trigger pulse |
| isample | input | 1 | Interrupt sample point, once per instruction |
| irq_lvl | input | 3 | Highest pending ordinary interrupt level (0 = none) |
| rst_exc | input | 1 | Reset exception processing begins |
| trc_exc | input | 1 | Trace exception processing begins |
| rte_done | input | 1 | Return-from-exception instruction completed |
| instr_ret | input | 1 | An instruction retired |
| ctl_emu | input | 1 | Enter emulator mode on reset exception |
| ctl_trc | input | 1 | Enter emulator mode on trace exception |
| ctl_map | input | 1 | Redirect accesses in emulator mode |
| acc_ifetch | input | 1 | Current access is an instruction fetch |
| tt_in | input | 2 | Transfer type from the core |
| tm_in | input | 3 | Transfer modifier from the core |
| dbg_pend | output | 1 | Debug interrupt pending |
| dbg_take | output | 1 | Debug interrupt accepted this cycle |
| irq_take | output | 1 | Ordinary interrupt accepted this cycle |
| vec_num | output | 8 | Exception vector number |
| pst | output | 4 | Processor status code |
| emu_mode | output | 1 | Core in emulator mode |
| tt_out | output | 2 | Transfer type to memory |
| tm_out | output | 3 | Transfer modifier to memory |
| cache_off | output | 1 | Caching and on-chip SRAM disabled |

## Verification
The two functions that meet in one cycle are the debug request and the ordinary interrupt, which compete at the same sample strobe. The bench holds `irq_lvl` at 7, and also at a lower level, during the strobe that accepts a pending or freshly arriving breakpoint. It expects `dbg_take` with vector 12 and no `irq_take`. A second collision puts a breakpoint, together with a sample strobe, in the window just after a return from emulator mode. There nothing may be taken until an instruction has retired.

// File: rtl/dbg_emu_pkg.sv
// Package: shared constants of the debug emulator mode controller.
// Assumes: widths used elsewhere default to 4-bit status, 8-bit vector.
package dbg_emu_pkg;
    localparam logic [3:0] PST_IDLE  = 4'h0;
    localparam logic [3:0] PST_DBG   = 4'hD;
    localparam logic [7:0] VEC_DEBUG = 8'd12;
    localparam int unsigned TT_EMU       = 2;
    localparam int unsigned TM_EMU_DATA  = 5;
    localparam int unsigned TM_EMU_FETCH = 6;
endpackage

// File: rtl/dbg_req_arb.sv
// Module: debug request arbiter.
// Holds a breakpoint request until the interrupt sample point and grants it
// above every ordinary interrupt level. It discards triggers while in
// emulator mode and in the post-exit window, which ends at the next
// instruction retire.
// Assumes: single-cycle pulses on brk_trig, isample, rte_done, instr_ret.
module dbg_req_arb #(
    parameter int unsigned IRQ_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             brk_trig,
    input  logic             isample,
    input  logic [IRQ_W-1:0] irq_lvl,
    input  logic             emu_mode,
    input  logic             rte_done,
    input  logic             instr_ret,
    output logic             dbg_pend,
    output logic             dbg_take,
    output logic             irq_take
);
    logic inhibit_q;
    logic trig_ok;

    // Accept a trigger only outside emulator mode and outside the post-exit window.
    always_comb trig_ok = brk_trig && !inhibit_q && !emu_mode;

    // Grant at the sample point; a debug grant suppresses any ordinary interrupt.
    always_comb begin
        dbg_take = isample && !emu_mode && (dbg_pend || trig_ok);
        irq_take = isample && !emu_mode && (irq_lvl != '0) && !dbg_take;
    end

    // Pending request: set on an accepted trigger, cleared when granted.
    always_ff @(posedge clk) begin
        if (!rst_n) dbg_pend <= 1'b0;
        else        dbg_pend <= (dbg_pend || trig_ok) && !dbg_take;
    end

    // Post-exit block: set when emulator mode ends, cleared by an instruction retire.
    always_ff @(posedge clk) begin
        if (!rst_n)                     inhibit_q <= 1'b0;
        else if (rte_done && emu_mode)  inhibit_q <= 1'b1;
        else if (instr_ret)             inhibit_q <= 1'b0;
    end
endmodule

// File: rtl/emu_mode_ctl.sv
// Module: emulator mode state and status code sequencer.
// Enters emulator mode on a debug grant, or on a reset or trace exception when
// its control bit is set, and leaves it on return-from-exception. Drives the
// debug status code for PST_HOLD cycles after each debug grant.
// Assumes: entry events take priority over an exit in the same cycle.
module emu_mode_ctl #(
    parameter int unsigned PST_HOLD = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dbg_take,
    input  logic       rst_exc,
    input  logic       trc_exc,
    input  logic       ctl_emu,
    input  logic       ctl_trc,
    input  logic       rte_done,
    output logic       emu_mode,
    output logic [3:0] pst
);
    import dbg_emu_pkg::*;

    localparam int unsigned CNT_W = $clog2(PST_HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(PST_HOLD);

    logic             enter;
    logic [CNT_W-1:0] hold_cnt;

    // Any of the three entry routes.
    always_comb enter = dbg_take || (rst_exc && ctl_emu) || (trc_exc && ctl_trc);

    // Mode register: entry wins, return-from-exception leaves.
    always_ff @(posedge clk) begin
        if (!rst_n)        emu_mode <= 1'b0;
        else if (enter)    emu_mode <= 1'b1;
        else if (rte_done) emu_mode <= 1'b0;
    end

    // Status hold counter, loaded on each debug grant.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hold_cnt <= '0;
        else if (dbg_take)           hold_cnt <= HOLD_LOAD;
        else if (hold_cnt != '0)     hold_cnt <= hold_cnt - 1'b1;
    end

    // Status code: debug code while the counter runs, idle otherwise.
    always_comb pst = (hold_cnt != '0) ? PST_DBG : PST_IDLE;
endmodule

// File: rtl/emu_space_map.sv
// Module: access space override.
// In emulator mode with the map bit set, forces every access into the debug
// address space and disables caching and on-chip SRAM; otherwise passes the
// transfer attributes through.
// Assumes: purely combinational, attributes valid in the access cycle.
module emu_space_map #(
    parameter int unsigned TT_W = 2,
    parameter int unsigned TM_W = 3
) (
    input  logic            emu_mode,
    input  logic            ctl_map,
    input  logic            acc_ifetch,
    input  logic [TT_W-1:0] tt_in,
    input  logic [TM_W-1:0] tm_in,
    output logic [TT_W-1:0] tt_out,
    output logic [TM_W-1:0] tm_out,
    output logic            cache_off
);
    import dbg_emu_pkg::*;

    localparam logic [TT_W-1:0] TT_FORCED = TT_W'(TT_EMU);
    localparam logic [TM_W-1:0] TM_DATA   = TM_W'(TM_EMU_DATA);
    localparam logic [TM_W-1:0] TM_FETCH  = TM_W'(TM_EMU_FETCH);

    logic redirect;

    // Select forced or passed-through attributes.
    always_comb begin
        redirect  = emu_mode && ctl_map;
        cache_off = redirect;
        tt_out    = redirect ? TT_FORCED : tt_in;
        tm_out    = redirect ? (acc_ifetch ? TM_FETCH : TM_DATA) : tm_in;
    end
endmodule

// File: rtl/dbg_emu_ctrl.sv
// Module: debug emulator mode controller, top level.
// Joins the request arbiter, the mode sequencer and the access space override,
// and presents the debug vector number during a debug grant.
// Assumes: all inputs synchronous to clk; reset is synchronous active-low.
module dbg_emu_ctrl #(
    parameter int unsigned IRQ_W    = 3,
    parameter int unsigned TT_W     = 2,
    parameter int unsigned TM_W     = 3,
    parameter int unsigned PST_HOLD = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             brk_trig,
    input  logic             isample,
    input  logic [IRQ_W-1:0] irq_lvl,
    input  logic             rst_exc,
    input  logic             trc_exc,
    input  logic             rte_done,
    input  logic             instr_ret,
    input  logic             ctl_emu,
    input  logic             ctl_trc,
    input  logic             ctl_map,
    input  logic             acc_ifetch,
    input  logic [TT_W-1:0]  tt_in,
    input  logic [TM_W-1:0]  tm_in,
    output logic             dbg_pend,
    output logic             dbg_take,
    output logic             irq_take,
    output logic [7:0]       vec_num,
    output logic [3:0]       pst,
    output logic             emu_mode,
    output logic [TT_W-1:0]  tt_out,
    output logic [TM_W-1:0]  tm_out,
    output logic             cache_off
);
    import dbg_emu_pkg::*;

    dbg_req_arb #(.IRQ_W(IRQ_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .brk_trig  (brk_trig),
        .isample   (isample),
        .irq_lvl   (irq_lvl),
        .emu_mode  (emu_mode),
        .rte_done  (rte_done),
        .instr_ret (instr_ret),
        .dbg_pend  (dbg_pend),
        .dbg_take  (dbg_take),
        .irq_take  (irq_take)
    );

    emu_mode_ctl #(.PST_HOLD(PST_HOLD)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .dbg_take (dbg_take),
        .rst_exc  (rst_exc),
        .trc_exc  (trc_exc),
        .ctl_emu  (ctl_emu),
        .ctl_trc  (ctl_trc),
        .rte_done (rte_done),
        .emu_mode (emu_mode),
        .pst      (pst)
    );

    emu_space_map #(.TT_W(TT_W), .TM_W(TM_W)) u_map (
        .emu_mode   (emu_mode),
        .ctl_map    (ctl_map),
        .acc_ifetch (acc_ifetch),
        .tt_in      (tt_in),
        .tm_in      (tm_in),
        .tt_out     (tt_out),
        .tm_out     (tm_out),
        .cache_off  (cache_off)
    );

    // Vector number is presented only while the debug grant is active.
    always_comb vec_num = dbg_take ? VEC_DEBUG : 8'd0;
endmodule

// File: rtl/dbg_emu_chk.sv
// Module: property checker for dbg_emu_ctrl, attached by bind.
// Assumes: default parameters (2-bit transfer type, 4-bit status).
module dbg_emu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       isample,
    input logic       rst_exc,
    input logic       trc_exc,
    input logic       rte_done,
    input logic       ctl_map,
    input logic       dbg_pend,
    input logic       dbg_take,
    input logic       irq_take,
    input logic [3:0] pst,
    input logic       emu_mode,
    input logic [1:0] tt_out,
    input logic       cache_off
);
    // R2: a pending request survives until a sample point.
    a_r2_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_pend && !isample |=> dbg_pend);
    // R2: a grant consumes the request.
    a_r2_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_take |=> !dbg_pend);
    // R4: never both grants in one cycle.
    a_r4_dbg_over_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbg_take && irq_take));
    // R6: status code shows the debug value right after a grant.
    a_r6_pst_code: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_take |=> pst == 4'hD);
    // R7: a grant enters emulator mode.
    a_r7_entry: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_take |=> emu_mode);
    // R10: no grants in emulator mode.
    a_r10_quiet_in_emu: assert property (@(posedge clk) disable iff (!rst_n)
        emu_mode |-> !irq_take && !dbg_take);
    // R11: return-from-exception leaves the mode.
    a_r11_exit: assert property (@(posedge clk) disable iff (!rst_n)
        emu_mode && rte_done && !rst_exc && !trc_exc |=> !emu_mode);
    // R12: mapped accesses use the debug space with caching off.
    a_r12_map_space: assert property (@(posedge clk) disable iff (!rst_n)
        emu_mode && ctl_map |-> tt_out == 2'd2 && cache_off);
endmodule

bind dbg_emu_ctrl dbg_emu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .isample   (isample),
    .rst_exc   (rst_exc),
    .trc_exc   (trc_exc),
    .rte_done  (rte_done),
    .ctl_map   (ctl_map),
    .dbg_pend  (dbg_pend),
    .dbg_take  (dbg_take),
    .irq_take  (irq_take),
    .pst       (pst),
    .emu_mode  (emu_mode),
    .tt_out    (tt_out),
    .cache_off (cache_off)
);

// File: tb/tb_dbg_emu_ctrl.sv
module tb_dbg_emu_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       brk_trig = 0, isample = 0, rst_exc = 0, trc_exc = 0;
    logic       rte_done = 0, instr_ret = 0, ctl_emu = 0, ctl_trc = 0;
    logic       ctl_map = 0, acc_ifetch = 0;
    logic [2:0] irq_lvl = '0;
    logic [1:0] tt_in = '0;
    logic [2:0] tm_in = '0;
    logic       dbg_pend, dbg_take, irq_take, emu_mode, cache_off;
    logic [7:0] vec_num;
    logic [3:0] pst;
    logic [1:0] tt_out;
    logic [2:0] tm_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    dbg_emu_ctrl dut (
        .clk(clk), .rst_n(rst_n), .brk_trig(brk_trig), .isample(isample),
        .irq_lvl(irq_lvl), .rst_exc(rst_exc), .trc_exc(trc_exc),
        .rte_done(rte_done), .instr_ret(instr_ret), .ctl_emu(ctl_emu),
        .ctl_trc(ctl_trc), .ctl_map(ctl_map), .acc_ifetch(acc_ifetch),
        .tt_in(tt_in), .tm_in(tm_in), .dbg_pend(dbg_pend), .dbg_take(dbg_take),
        .irq_take(irq_take), .vec_num(vec_num), .pst(pst), .emu_mode(emu_mode),
        .tt_out(tt_out), .tm_out(tm_out), .cache_off(cache_off)
    );

    typedef struct packed {
        logic       emu;
        logic       map;
        logic       ifetch;
        logic [1:0] tt;
        logic [2:0] tm;
        logic [1:0] exp_tt;
        logic [2:0] exp_tm;
        logic       exp_cache;
    } vec_t;

    // Access space vectors for R12: {emu, map, ifetch, tt, tm, exp_tt, exp_tm, exp_cache}
    localparam vec_t VEC [0:7] = '{
        '{1'b0, 1'b0, 1'b0, 2'd1, 3'd3, 2'd1, 3'd3, 1'b0},
        '{1'b0, 1'b1, 1'b1, 2'd0, 3'd2, 2'd0, 3'd2, 1'b0},
        '{1'b1, 1'b0, 1'b0, 2'd3, 3'd7, 2'd3, 3'd7, 1'b0},
        '{1'b1, 1'b1, 1'b0, 2'd0, 3'd1, 2'd2, 3'd5, 1'b1},
        '{1'b1, 1'b1, 1'b1, 2'd1, 3'd4, 2'd2, 3'd6, 1'b1},
        '{1'b0, 1'b1, 1'b0, 2'd2, 3'd5, 2'd2, 3'd5, 1'b0},
        '{1'b1, 1'b1, 1'b1, 2'd3, 3'd0, 2'd2, 3'd6, 1'b1},
        '{1'b1, 1'b0, 1'b1, 2'd0, 3'd6, 2'd0, 3'd6, 1'b0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic enter_emu();
        ctl_trc = 1; trc_exc = 1; tick(); trc_exc = 0; ctl_trc = 0;
    endtask

    task automatic leave_emu();
        rte_done = 1; tick(); rte_done = 0;
        instr_ret = 1; tick(); instr_ret = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: events during reset are ignored
        ctl_emu = 1; rst_exc = 1; brk_trig = 1;
        repeat (3) tick();
        rst_exc = 0; brk_trig = 0; ctl_emu = 0; rst_n = 1;
        tick(); settle();
        chk("R1", "emu_mode", emu_mode, 0);
        chk("R1", "dbg_pend", dbg_pend, 0);
        chk("R1", "pst", pst, 0);
        chk("R1", "dbg_take", dbg_take, 0);

        // Vector walk: access space override
        foreach (VEC[i]) begin
            if (VEC[i].emu && !emu_mode) enter_emu();
            if (!VEC[i].emu && emu_mode) leave_emu();
            ctl_map = VEC[i].map; acc_ifetch = VEC[i].ifetch;
            tt_in = VEC[i].tt; tm_in = VEC[i].tm;
            settle();
            chk("R12", "emu_mode", emu_mode, VEC[i].emu);
            chk("R12", "tt_out", tt_out, VEC[i].exp_tt);
            chk("R12", "tm_out", tm_out, VEC[i].exp_tm);
            chk("R12", "cache_off", cache_off, VEC[i].exp_cache);
            tick();
        end
        ctl_map = 0;
        if (emu_mode) leave_emu();

        // R4: ordinary interrupt with nothing pending
        irq_lvl = 5; isample = 1; settle();
        chk("R4", "irq_take", irq_take, 1);
        chk("R5", "vec_num idle", vec_num, 0);
        tick(); isample = 0; irq_lvl = 0;

        // R2: trigger held until sample point
        brk_trig = 1; tick(); brk_trig = 0; settle();
        chk("R2", "dbg_pend", dbg_pend, 1);
        chk("R2", "dbg_take early", dbg_take, 0);
        tick(); settle();
        chk("R2", "dbg_pend held", dbg_pend, 1);
        isample = 1; irq_lvl = 7; settle();
        chk("R2", "dbg_take", dbg_take, 1);
        chk("R4", "irq_take lvl7", irq_take, 0);
        chk("R5", "vec_num", vec_num, 12);
        tick(); isample = 0; irq_lvl = 0; settle();
        chk("R7", "emu_mode", emu_mode, 1);
        chk("R2", "dbg_pend cleared", dbg_pend, 0);
        chk("R6", "pst c1", pst, 13);
        tick(); settle(); chk("R6", "pst c2", pst, 13);
        tick(); settle(); chk("R6", "pst c3", pst, 13);
        tick(); settle(); chk("R6", "pst after", pst, 0);

        // R10: quiet in emulator mode
        irq_lvl = 7; isample = 1; brk_trig = 1; settle();
        chk("R10", "irq_take", irq_take, 0);
        chk("R10", "dbg_take", dbg_take, 0);
        tick(); isample = 0; brk_trig = 0; irq_lvl = 0;
        tick();

        // R11: exit and post-exit block
        rte_done = 1; tick(); rte_done = 0; settle();
        chk("R11", "emu_mode", emu_mode, 0);
        chk("R10", "dbg_pend after exit", dbg_pend, 0);
        brk_trig = 1; tick(); brk_trig = 0; settle();
        chk("R11", "dbg_pend blocked", dbg_pend, 0);
        brk_trig = 1; isample = 1; settle();
        chk("R11", "dbg_take blocked", dbg_take, 0);
        tick(); brk_trig = 0; isample = 0;
        instr_ret = 1; tick(); instr_ret = 0;

        // R3: trigger on the sample point is taken at once
        brk_trig = 1; isample = 1; irq_lvl = 3; settle();
        chk("R3", "dbg_take", dbg_take, 1);
        chk("R4", "irq_take", irq_take, 0);
        tick(); brk_trig = 0; isample = 0; irq_lvl = 0; settle();
        chk("R3", "emu_mode", emu_mode, 1);
        leave_emu();

        // R8: reset exception entry
        ctl_emu = 0; rst_exc = 1; tick(); rst_exc = 0; settle();
        chk("R8", "emu clear bit", emu_mode, 0);
        ctl_emu = 1; rst_exc = 1; tick(); rst_exc = 0; ctl_emu = 0; settle();
        chk("R8", "emu set bit", emu_mode, 1);
        leave_emu();

        // R9: trace exception entry
        ctl_trc = 0; trc_exc = 1; tick(); trc_exc = 0; settle();
        chk("R9", "emu clear bit", emu_mode, 0);
        ctl_trc = 1; trc_exc = 1; tick(); trc_exc = 0; ctl_trc = 0; settle();
        chk("R9", "emu set bit", emu_mode, 1);
        leave_emu();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule